// File: doc/BRIEF.md
# Three-Phase Voltage Sag Monitor

This block watches three signed voltage sample streams, one per phase. The samples have already been high-pass filtered upstream. For each valid sample it takes the magnitude of every phase and compares it with a programmable 24-bit level. When a phase falls below that level, the block records a sag event. The event goes into a sticky status bit and into a per-phase attribution register. It pulls an active-low interrupt line when the host has enabled that status bit in the mask.

The host reaches four 32-bit registers through a small write/read port. It sets the level, sets the interrupt enables, and inspects and acknowledges events. Status bits are cleared by writing a one to them. Two threshold codes behave specially. A level at or above the full-scale code flags every sample, and a level of zero or one disables detection entirely.

Top module: `sag_monitor`

## Requirements
- R1: After reset, `irq_n` is high and all four registers read as zero.
- R2: A sag hit needs all of the following, and is recorded at the next clock edge:
  - `smp_valid` is high and the level lies in 2..0x5A753F.
  - The phase's sample, taken as two's complement with magnitude `|x|`, has a magnitude strictly below the level.
  - Phase n occupies `smp_data[24n+23:24n]` (A=0, B=1, C=2).
  - On the hit, bit 16 of the status register (address 2) is set and bit n of the phase register (address 3) is set.
- R3: With the level at 0x000000 or 0x000001, no sample ever raises a sag event.
- R4: With the level at or above 0x5A7540, every valid sample raises a sag event on all three phases.
- R5: The level register at address 0 stores write data bits [23:0]. Bits [31:24] always read as zero.
- R6: The status register at address 2 reports the sag flag in bit 16. Writing it with bit 16 set clears the flag at the next edge, and writing it with bit 16 clear leaves the flag unchanged. A sag hit in the same cycle as a clearing write keeps the flag set.
- R7: The phase register at address 3 holds one sticky bit per phase in bits [2:0]. Each bit is cleared by writing a one to it, and a hit in the same cycle wins over the clear.
- R8: The mask register at address 1 stores and reads back all 32 bits. `irq_n` is low exactly when some status bit is set while the matching mask bit is set.
- R9: While `smp_valid` is low, sample data has no effect on any register or on `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe for all three phases |
| smp_data | input | 72 | Three packed signed samples, phase A in the low 24 bits |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 level, 1 mask, 2 status, 3 phase |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench drives the two disabling level codes with zero-magnitude samples. A detector that used a plain less-than test would fire there on a level of one.

It pushes the level to full scale and beyond with samples at the positive and negative extremes. A design that compared magnitudes instead of forcing the full-scale behaviour would miss those.

It lands a clearing write in the same cycle as a new hit. A design that let the clear win would lose the event.

Random levels, masks, samples and strobes then run against a bench model. This exposes any wrong phase attribution, mask gating or read-back width.

// File: rtl/sagmon_pkg.sv
package sagmon_pkg;

   typedef enum logic [1:0] {
      RA_LEVEL = 2'd0,
      RA_MASK  = 2'd1,
      RA_STS   = 2'd2,
      RA_PHS   = 2'd3
   } reg_addr_e;

endpackage

// File: rtl/sagmon_mag.sv
module sagmon_mag #(
   parameter int W = 24
) (
   input  logic [W-1:0] smp,
   output logic [W-1:0] mag
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};

   always_comb begin
      if (smp == MOST_NEG)
         mag = MAX_POS;
      else if (smp[W-1])
         mag = ~smp + 1'b1;
      else
         mag = smp;
   end
endmodule

// File: rtl/sagmon_cmp.sv
module sagmon_cmp #(
   parameter int          W          = 24,
   parameter int unsigned FULL_SCALE = 24'h5A7540,
   parameter bit          INCLUSIVE  = 1'b0
) (
   input  logic [W-1:0] mag,
   input  logic [W-1:0] level,
   output logic         hit
);
   localparam logic [W-1:0] FS = W'(FULL_SCALE);

   logic below;
   logic always_on;
   logic disabled;

   generate
      if (INCLUSIVE) begin : g_le
         assign below = (mag <= level);
      end else begin : g_lt
         assign below = (mag < level);
      end
   endgenerate

   assign always_on = (level >= FS);
   assign disabled  = (level <= W'(1));
   assign hit       = always_on | (~disabled & below);
endmodule

// File: rtl/sagmon_regs.sv
module sagmon_regs
   import sagmon_pkg::*;
#(
   parameter int          W          = 24,
   parameter int          NPH        = 3,
   parameter int          DW         = 32,
   parameter int          SAG_BIT    = 16,
   parameter int unsigned FULL_SCALE = 24'h5A7540
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_valid,
   input  logic [NPH-1:0] hits,
   input  logic           reg_wen,
   input  logic [1:0]     reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [W-1:0]   level_q,
   output logic [DW-1:0]  reg_rdata,
   output logic           irq_n
);
   logic [DW-1:0]  mask_q;
   logic           sts_q;
   logic [NPH-1:0] phs_q;
   logic [NPH-1:0] phs_clr;
   logic [DW-1:0]  sts_word;
   logic           wr_level, wr_mask, wr_sts, wr_phs;

   assign wr_level = reg_wen && (reg_addr_e'(reg_addr) == RA_LEVEL);
   assign wr_mask  = reg_wen && (reg_addr_e'(reg_addr) == RA_MASK);
   assign wr_sts   = reg_wen && (reg_addr_e'(reg_addr) == RA_STS);
   assign wr_phs   = reg_wen && (reg_addr_e'(reg_addr) == RA_PHS);
   assign phs_clr  = wr_phs ? reg_wdata[NPH-1:0] : '0;

   always_comb begin
      sts_word          = '0;
      sts_word[SAG_BIT] = sts_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         mask_q  <= '0;
         sts_q   <= 1'b0;
         phs_q   <= '0;
      end else begin
         if (wr_level) level_q <= reg_wdata[W-1:0];
         if (wr_mask)  mask_q  <= reg_wdata;
         if (|hits)
            sts_q <= 1'b1;
         else if (wr_sts && reg_wdata[SAG_BIT])
            sts_q <= 1'b0;
         phs_q <= (phs_q & ~phs_clr) | hits;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr_e'(reg_addr))
         RA_LEVEL: reg_rdata[W-1:0]   = level_q;
         RA_MASK:  reg_rdata          = mask_q;
         RA_STS:   reg_rdata          = sts_word;
         RA_PHS:   reg_rdata[NPH-1:0] = phs_q;
         default:  reg_rdata          = '0;
      endcase
   end

   assign irq_n = ~|(sts_word & mask_q);

   AST_LEVEL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_e'(reg_addr) == RA_LEVEL) |-> (reg_rdata[DW-1:W] == '0)); // R5
   AST_NEVER_BELOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q <= W'(1)) |-> (hits == '0)); // R3
   AST_FULL_ALL_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && (level_q >= W'(FULL_SCALE))) |-> (&hits)); // R4
   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> (hits == '0)); // R9
   AST_W1C_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && reg_wdata[SAG_BIT] && (hits == '0)) |=> !sts_q); // R6
   AST_PHASE_RISE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(phs_q & ~$past(phs_q))) |-> sts_q); // R7
   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> mask_q[SAG_BIT]); // R8
endmodule

// File: rtl/sag_monitor.sv
module sag_monitor #(
   parameter int          W          = 24,
   parameter int          NPH        = 3,
   parameter int          DW         = 32,
   parameter int          SAG_BIT    = 16,
   parameter int unsigned FULL_SCALE = 24'h5A7540,
   parameter bit          INCLUSIVE  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [NPH*W-1:0] smp_data,
   input  logic             reg_wen,
   input  logic [1:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             irq_n
);
   generate
      if (W < 2 || W >= DW) begin : g_bad_w
         $error("sag_monitor: W must lie in 2..DW-1");
      end
      if (NPH < 1 || NPH > DW) begin : g_bad_nph
         $error("sag_monitor: NPH must lie in 1..DW");
      end
      if (SAG_BIT < 0 || SAG_BIT >= DW) begin : g_bad_bit
         $error("sag_monitor: SAG_BIT outside data word");
      end
      if (FULL_SCALE < 2 || (FULL_SCALE >> W) != 0) begin : g_bad_fs
         $error("sag_monitor: FULL_SCALE must fit W bits and exceed 1");
      end
   endgenerate

   logic [W-1:0]   level_q;
   logic [NPH-1:0] raw_hit;
   logic [NPH-1:0] hits;

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      logic [W-1:0] mag;

      sagmon_mag #(.W(W)) u_mag (
         .smp (smp_data[p*W +: W]),
         .mag (mag)
      );

      sagmon_cmp #(.W(W), .FULL_SCALE(FULL_SCALE), .INCLUSIVE(INCLUSIVE)) u_cmp (
         .mag   (mag),
         .level (level_q),
         .hit   (raw_hit[p])
      );
   end

   assign hits = smp_valid ? raw_hit : '0;

   sagmon_regs #(
      .W(W), .NPH(NPH), .DW(DW), .SAG_BIT(SAG_BIT), .FULL_SCALE(FULL_SCALE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .hits      (hits),
      .reg_wen   (reg_wen),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .level_q   (level_q),
      .reg_rdata (reg_rdata),
      .irq_n     (irq_n)
   );
endmodule

// File: tb/sim_sag_monitor.sv
`timescale 1ns/1ps
module sim_sag_monitor;
   localparam logic [23:0] FS = 24'h5A7540;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [71:0] smp_data = '0;
   logic        reg_wen = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_n;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   logic [23:0] m_level = '0;
   logic [31:0] m_mask = '0;
   logic        m_sts = 1'b0;
   logic [2:0]  m_phs = '0;

   always #4 clk = ~clk;

   sag_monitor u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   function automatic logic [23:0] mag_of(input logic [23:0] x);
      if (x == 24'h800000) return 24'h7FFFFF;
      return x[23] ? (~x + 24'd1) : x;
   endfunction

   function automatic bit ref_hit(input logic [23:0] lvl, input logic [23:0] x);
      if (lvl >= FS) return 1'b1;
      if (lvl <= 24'd1) return 1'b0;
      return mag_of(x) < lvl;
   endfunction

   function automatic logic [31:0] ref_read(input logic [1:0] a);
      case (a)
         2'd0: return {8'h00, m_level};
         2'd1: return m_mask;
         2'd2: return {15'd0, m_sts, 16'd0};
         default: return {29'd0, m_phs};
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] a);
      case (a)
         2'd0: return "R5";
         2'd1: return "R8";
         2'd2: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: drive, compare outputs against model state, then advance the model
   task automatic cyc(input bit v, input logic [71:0] d, input bit we,
                      input logic [1:0] ad, input logic [31:0] wd);
      logic [2:0] h;
      @(negedge clk);
      smp_valid = v; smp_data = d; reg_wen = we; reg_addr = ad; reg_wdata = wd;
      #1;
      chk(irq_n == ~(m_sts & m_mask[16]), "R8 irq", {31'd0, irq_n}, {31'd0, ~(m_sts & m_mask[16])});
      if (!we) chk(reg_rdata == ref_read(ad), tag_of(ad), reg_rdata, ref_read(ad));
      @(posedge clk);
      for (int p = 0; p < 3; p++) h[p] = v & ref_hit(m_level, d[p*24 +: 24]);
      if (|h) m_sts = 1'b1;
      else if (we && ad == 2'd2 && wd[16]) m_sts = 1'b0;
      m_phs = (m_phs & ~((we && ad == 2'd3) ? wd[2:0] : 3'd0)) | h;
      if (we && ad == 2'd0) m_level = wd[23:0];
      if (we && ad == 2'd1) m_mask = wd;
   endtask

   task automatic expect_rd(input logic [1:0] ad, input logic [31:0] exp, input string tag);
      @(negedge clk);
      smp_valid = 1'b0; reg_wen = 1'b0; reg_addr = ad;
      #1;
      chk(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   task automatic expect_irq(input bit exp, input string tag);
      @(negedge clk);
      smp_valid = 1'b0; reg_wen = 1'b0;
      #1;
      chk(irq_n == exp, tag, {31'd0, irq_n}, {31'd0, exp});
   endtask

   task automatic wr(input logic [1:0] ad, input logic [31:0] wd);
      cyc(1'b0, '0, 1'b1, ad, wd);
   endtask

   task automatic smp(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c, input bit v);
      cyc(v, {c, b, a}, 1'b0, 2'd0, '0);
   endtask

   initial begin
      #1600000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [23:0] lv, sa, sb, sc;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 4; a++) expect_rd(2'(a), 32'd0, "R1");
      expect_irq(1'b1, "R1 irq");

      // R2: single-phase sag with mask enabled
      wr(2'd1, 32'h0001_0000);
      wr(2'd0, 32'h0000_0100);
      smp(24'h000010, 24'h000100, 24'h7FFFFF, 1'b1);
      expect_rd(2'd3, 32'h1, "R2 phase A only");
      expect_rd(2'd2, 32'h0001_0000, "R2 status");
      expect_irq(1'b0, "R8 irq low");
      smp(24'h000000, 24'hFFFFF0, 24'h000000, 1'b1);
      expect_rd(2'd3, 32'h7, "R2 negative sample");

      // R6: write zero keeps, write one clears
      wr(2'd2, 32'h0000_0000);
      expect_rd(2'd2, 32'h0001_0000, "R6 zero keeps");
      wr(2'd2, 32'h0001_0000);
      expect_rd(2'd2, 32'h0, "R6 clear");
      expect_irq(1'b1, "R8 irq released");
      // R7: per-bit clear
      wr(2'd3, 32'h2);
      expect_rd(2'd3, 32'h5, "R7 bit clear");
      wr(2'd3, 32'h7);

      // R3: disabling codes
      wr(2'd0, 32'h0000_0001);
      smp(24'h000000, 24'h000000, 24'h000000, 1'b1);
      wr(2'd0, 32'h0000_0000);
      smp(24'h000000, 24'h000000, 24'h000000, 1'b1);
      expect_rd(2'd2, 32'h0, "R3 no status");
      expect_rd(2'd3, 32'h0, "R3 no phase");

      // R4: full scale and above
      wr(2'd0, {8'h00, FS});
      smp(24'h7FFFFF, 24'h800000, 24'h000000, 1'b1);
      expect_rd(2'd3, 32'h7, "R4 all phases");
      wr(2'd3, 32'h7);
      wr(2'd2, 32'h0001_0000);

      // R9: strobe low
      smp(24'h000000, 24'h000000, 24'h000000, 1'b0);
      expect_rd(2'd2, 32'h0, "R9 no status");
      expect_rd(2'd3, 32'h0, "R9 no phase");
      expect_irq(1'b1, "R9 irq");

      // R6/R7: hit wins over simultaneous clear
      cyc(1'b1, '0, 1'b1, 2'd2, 32'h0001_0000);
      expect_rd(2'd2, 32'h0001_0000, "R6 hit wins");
      cyc(1'b1, '0, 1'b1, 2'd3, 32'h7);
      expect_rd(2'd3, 32'h7, "R7 hit wins");

      // R5: upper byte dropped
      wr(2'd0, 32'hFFFF_FFFF);
      expect_rd(2'd0, 32'h00FF_FFFF, "R5 upper zero");
      wr(2'd1, 32'hA5A5_5A5A);
      expect_rd(2'd1, 32'hA5A5_5A5A, "R8 mask readback");

      // random phase
      for (int i = 0; i < 2000; i++) begin
         int unsigned r;
         r = $urandom % 16;
         if (r == 0) begin
            case ($urandom % 5)
               0: lv = 24'd0;
               1: lv = 24'd1;
               2: lv = FS + 24'($urandom % 256);
               3: lv = 24'($urandom % 512);
               default: lv = 24'($urandom % 24'h5A7540);
            endcase
            wr(2'd0, {$urandom, lv});
         end else if (r == 1) begin
            wr(2'd1, ($urandom % 2) ? 32'h0001_0000 : $urandom);
         end else if (r == 2) begin
            wr(2'd2, $urandom);
         end else if (r == 3) begin
            wr(2'd3, $urandom);
         end else begin
            sa = ($urandom % 2) ? 24'($urandom) : 24'($urandom % 1024) - 24'd512;
            sb = ($urandom % 2) ? 24'($urandom) : 24'($urandom % 1024) - 24'd512;
            sc = ($urandom % 2) ? 24'($urandom) : 24'($urandom % 1024) - 24'd512;
            cyc(($urandom % 4) != 0, {sc, sb, sa}, 1'b0, 2'($urandom), '0);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule